// File: doc/BRIEF.md
# Codec Control Pair Double Buffer

This block sits between a processor write port and the serial frame composer of an audio output path. Software hands it a pair of 16-bit codec control words in one write. The pair lands in a staging (buffer) register. At the next frame boundary reported by the serial side, both words move together into a shadow register, and the frame composer reads from there. Because the shadow register only changes at a frame start, no frame ever carries one old word and one new word.

A busy flag is raised by every write. It drops once the staged pair has been copied into the shadow register. Software polls this flag before it writes the next pair, and can step a codec through a sequence of control settings one frame at a time. Between writes the shadow words stay as they are and go out in every frame. The flag raises no interrupt.

Top module: `cc_dbuf`

## Requirements
- R1: A write (`wr_i` high on a clock edge) captures `ctrl_a_i` and `ctrl_b_i` together. Both words reach the shadow outputs together at the next copy.
- R2: A write makes `busy_o` read 1 after that clock edge.
- R3: A frame start (`frame_i` high on a clock edge) while `busy_o` is 1 copies both staged words to `shadow_a_o`/`shadow_b_o` after that edge. If no write occurs in the same cycle, `busy_o` also clears after that edge.
- R4: While no new pair is written, the shadow outputs keep their values across any number of frame starts.
- R5: Reset gives `busy_o` = 0 and both shadow outputs = 0. This holds whether reset is applied at start-up or during operation.
- R6: A frame start while `busy_o` is 0 leaves the shadow outputs and `busy_o` unchanged.
- R7: A write made while `busy_o` is 1 replaces the staged pair and keeps `busy_o` at 1. Only the latest pair reaches the shadow outputs at the next copy.
- R8: When a write and a frame start fall on the same edge while `busy_o` is 1, the copy takes the previously staged pair and `busy_o` stays 1. The new pair then reaches the shadow at the following frame start.
- R9: Without a frame start, `busy_o` stays 1 indefinitely after a write. It has no timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Write strobe for a control pair |
| ctrl_a_i | input | 16 | First control word of the pair |
| ctrl_b_i | input | 16 | Second control word of the pair |
| frame_i | input | 1 | One-cycle frame-start pulse from the serial side |
| shadow_a_o | output | 16 | First control word used in frames |
| shadow_b_o | output | 16 | Second control word used in frames |
| busy_o | output | 1 | 1 while a staged pair awaits its copy |

## Verification
On every cycle, the assertions check how the busy flag responds to writes and frame starts. They also check that the shadow words change only on a copy, and that a copy moves exactly the staged pair held before that edge. The bench scenarios show the end-to-end results: a pair overwritten while busy, write and frame start landing on the same edge with either busy value, retransmission over repeated frames, and a reset applied during operation.

// File: rtl/cc_dbuf_pkg.sv
package cc_dbuf_pkg;

    localparam int unsigned LANES = 2;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'b00,
        ACT_STAGE = 2'b01,
        ACT_COPY  = 2'b10,
        ACT_BOTH  = 2'b11
    } cc_act_e;

endpackage

// File: rtl/cc_hs_ctrl.sv
module cc_hs_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_i,
    input  logic frame_i,
    output logic stage_o,
    output logic copy_o,
    output logic busy_o
);
    import cc_dbuf_pkg::*;

    typedef struct packed {
        logic busy;
    } st_t;

    st_t     st_d, st_q;
    cc_act_e act;

    always_comb begin
        act = cc_act_e'({frame_i & st_q.busy, wr_i});
        st_d = st_q;
        unique case (act)
            ACT_STAGE: st_d.busy = 1'b1;
            ACT_COPY:  st_d.busy = 1'b0;
            ACT_BOTH:  st_d.busy = 1'b1;
            default:   st_d.busy = st_q.busy;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stage_o = act[0];
    assign copy_o  = act[1];
    assign busy_o  = st_q.busy;

    a_r2_write_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> busy_o);
    a_r3_copy_clears_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_i && !wr_i) |=> !busy_o);
    a_r9_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !frame_i) |=> busy_o);
    a_r6_idle_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && frame_i) |-> !copy_o);
endmodule

// File: rtl/cc_pair_reg.sv
module cc_pair_reg #(
    parameter int unsigned W = 16
) (
    input  logic                                     clk_i,
    input  logic                                     rst_ni,
    input  logic                                     load_i,
    input  logic [cc_dbuf_pkg::LANES-1:0][W-1:0]     d_i,
    output logic [cc_dbuf_pkg::LANES-1:0][W-1:0]     q_o
);
    import cc_dbuf_pkg::*;

    typedef struct packed {
        logic [LANES-1:0][W-1:0] word;
    } st_t;

    st_t st_d, st_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            st_d.word[g] = load_i ? d_i[g] : st_q.word[g];
        end
        assign q_o[g] = st_q.word[g];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    a_r4_hold_without_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(q_o));
endmodule

// File: rtl/cc_dbuf.sv
module cc_dbuf #(
    parameter int unsigned CTRL_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] ctrl_a_i,
    input  logic [CTRL_W-1:0] ctrl_b_i,
    input  logic              frame_i,
    output logic [CTRL_W-1:0] shadow_a_o,
    output logic [CTRL_W-1:0] shadow_b_o,
    output logic              busy_o
);
    import cc_dbuf_pkg::*;

    logic                         stage, copy;
    logic [LANES-1:0][CTRL_W-1:0] wr_pair, stage_q, shadow_q;

    assign wr_pair[0] = ctrl_a_i;
    assign wr_pair[1] = ctrl_b_i;

    cc_hs_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_i),
        .frame_i (frame_i),
        .stage_o (stage),
        .copy_o  (copy),
        .busy_o  (busy_o)
    );

    cc_pair_reg #(.W(CTRL_W)) u_stage (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (stage),
        .d_i    (wr_pair),
        .q_o    (stage_q)
    );

    cc_pair_reg #(.W(CTRL_W)) u_shadow (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (copy),
        .d_i    (stage_q),
        .q_o    (shadow_q)
    );

    assign shadow_a_o = shadow_q[0];
    assign shadow_b_o = shadow_q[1];

    a_r1_pair_staged: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (stage_q[0] == $past(ctrl_a_i) && stage_q[1] == $past(ctrl_b_i)));
    a_r8_copy_takes_old_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_i && busy_o) |=> (shadow_a_o == $past(stage_q[0]) && shadow_b_o == $past(stage_q[1])));
    a_r4_shadow_only_on_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(frame_i && busy_o) |=> ($stable(shadow_a_o) && $stable(shadow_b_o)));
endmodule

// File: tb/tb_cc_dbuf.sv
module tb_cc_dbuf;
    localparam int W = 16;
    localparam int VW = 2 + 4*W + 1;
    localparam int NV = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr = 1'b0, fr = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic [W-1:0] sa, sb;
    logic         busy;
    int           total = 0, bad = 0;

    always #4 clk = ~clk;

    cc_dbuf #(.CTRL_W(W)) dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .ctrl_a_i(a), .ctrl_b_i(b),
        .frame_i(fr), .shadow_a_o(sa), .shadow_b_o(sb), .busy_o(busy)
    );

    // {wr, frame, a, b, exp_busy, exp_sa, exp_sb}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1,1'b0,16'h1111,16'h2222,1'b1,16'h0000,16'h0000}, // R2
        {1'b0,1'b0,16'h0000,16'h0000,1'b1,16'h0000,16'h0000}, // R9
        {1'b0,1'b1,16'h0000,16'h0000,1'b0,16'h1111,16'h2222}, // R3 R1
        {1'b0,1'b1,16'h0000,16'h0000,1'b0,16'h1111,16'h2222}, // R4 R6
        {1'b1,1'b0,16'h3333,16'h4444,1'b1,16'h1111,16'h2222}, // R2
        {1'b1,1'b0,16'h5555,16'h6666,1'b1,16'h1111,16'h2222}, // R7
        {1'b0,1'b1,16'h0000,16'h0000,1'b0,16'h5555,16'h6666}, // R7
        {1'b1,1'b1,16'h7777,16'h8888,1'b1,16'h5555,16'h6666}, // R6 R8
        {1'b1,1'b1,16'h9999,16'hAAAA,1'b1,16'h7777,16'h8888}, // R8
        {1'b0,1'b1,16'h0000,16'h0000,1'b0,16'h9999,16'hAAAA}, // R8
        {1'b0,1'b0,16'h0000,16'h0000,1'b0,16'h9999,16'hAAAA}  // R4
    };

    task automatic check(input bit ok, input string req, input logic [2*W:0] act, input logic [2*W:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input logic eb, input logic [W-1:0] ea, input logic [W-1:0] ebb);
        check({busy, sa, sb} === {eb, ea, ebb}, req, {busy, sa, sb}, {eb, ea, ebb});
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_state("R5 reset", 1'b0, '0, '0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {wr, fr, a, b} = VEC[i][VW-1 -: 2+2*W];
            @(negedge clk);
            wr = 1'b0; fr = 1'b0;
            check_state($sformatf("vector %0d R1-R9 table", i),
                        VEC[i][2*W], VEC[i][2*W-1 -: W], VEC[i][W-1:0]);
        end
        // R9: long wait with no frame
        @(negedge clk); wr = 1'b1; a = 16'hBEEF; b = 16'hCAFE;
        @(negedge clk); wr = 1'b0;
        repeat (50) @(negedge clk);
        check_state("R9 no timeout", 1'b1, 16'h9999, 16'hAAAA);
        // R5: reset mid-operation
        rst_n = 1'b0;
        @(negedge clk);
        check_state("R5 mid-run reset", 1'b0, '0, '0);
        rst_n = 1'b1;
        // R6: frame after reset with nothing staged
        fr = 1'b1; @(negedge clk); fr = 1'b0;
        check_state("R6 idle frame", 1'b0, '0, '0);
        // R1: both words move together after reset
        wr = 1'b1; a = 16'h0F0F; b = 16'hF0F0; @(negedge clk); wr = 1'b0;
        fr = 1'b1; @(negedge clk); fr = 1'b0;
        check_state("R1 pair together", 1'b0, 16'h0F0F, 16'hF0F0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule